// File: doc/BRIEF.md
# Selectable-Edge Shared Interrupt Front End

This block sits between the general-purpose pins and an interrupt controller. It produces eight interrupt request lines, each as a pulse one clock long. Each line takes its input from one of several places. Its default source is a Port A pin. Depending on the line, it can switch to a Port D pin of the same index, to a low-voltage-detect flag or to a comparator output.

A per-line polarity bit decides whether the line fires on a rising or a falling transition. All external signals are brought into the clock domain through two flip-flops before any edge is examined.

Software programs the block through a byte-wide register port. The port has two locations: a polarity register and a source-select register. A read returns the addressed byte on the following clock. A write that changes a line's source or polarity suppresses that line for one cycle, so that retargeting a line never raises a false request.

Top module: `edge_irq_frontend`

## Requirements
- R1: While reset is high, and on the first clock after reset, every request output is 0. The read data is 0, and both registers hold 0x00.
- R2: When a line's polarity bit is 0, a 1-to-0 change of its selected source gives a request pulse. The input is changed before clock edge e. The pulse is high after edge e+2 and lasts exactly one cycle.
- R3: When a line's polarity bit is 1, a 0-to-1 change of its selected source gives the same single-cycle pulse, with the same latency as in R2.
- R4: Source-select bit 7 chooses Port A pin 7 when it is 0 and the low-voltage-detect input when it is 1, for line 7.
- R5: Source-select bit 6 chooses Port A pin 6 when it is 0 and the comparator input when it is 1, for line 6.
- R6: For lines 1 to 5, source-select bit n chooses Port A pin n when it is 0 and Port D pin n when it is 1.
- R7: Source-select bit 0 can be written and read back but selects nothing. By default, line 0 always follows Port A pin 0.
- R8: A register write that changes the source or polarity bit of a line forces that line's request to 0 on the clock after the write. Lines whose bits did not change keep detecting edges in that same cycle.
- R9: A read with bus_rd high returns the stored byte on the next clock. The polarity register is at address 0xFCD and the source-select register at 0xFCE. Any other address reads 0x00.
- R10: The lines are independent. Edges on several lines in the same cycle give pulses on all of those lines in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| porta_in | input | 8 | Port A pin levels, asynchronous |
| portd_in | input | 8 | Port D pin levels, asynchronous |
| lvd_in | input | 1 | Low-voltage-detect flag, asynchronous |
| cmp_in | input | 1 | Comparator output, asynchronous |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 8 | Single-cycle request pulses, one per line |

## Verification
Two functions can land in the same clock: a register write that retargets a line, and a genuine synchronized transition on another line. The bench raises Port A pin 7 so that its synchronized edge arrives on the same clock that a write moves lines 1 to 5 from a low Port A source to a high Port D source. It expects exactly 0x80 on the request outputs in the next cycle. The masked lines must stay silent afterwards, and they must then fire again on a fresh rising edge of their new source.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned DATA_W = 8;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int unsigned WIDTH  = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  // no reset: during reset the chain fills with real pin levels
  always_ff @(posedge clk) begin
    chain_q[0] <= async_i;
    for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqfe_regs.sv
module irqfe_regs
  import irqfe_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]     POL_ADDR = 12'hFCD,
  parameter logic [ADDR_W-1:0]     SRC_ADDR = 12'hFCE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output line_vec_t         pol_o,
  output line_vec_t         src_o,
  output line_vec_t         hold_o
);
  line_vec_t        pol_q, src_q, hold_q;
  logic [DATA_W-1:0] rdata_q;
  logic             wr_pol, wr_src;
  line_vec_t        src_eff_mask;

  assign wr_pol = wr_i && (addr_i == POL_ADDR);
  assign wr_src = wr_i && (addr_i == SRC_ADDR);
  // bit 0 of the source register steers nothing
  assign src_eff_mask = {{(LINES-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      src_q  <= '0;
      hold_q <= '0;
    end else begin
      hold_q <= '0;
      if (wr_pol) begin
        pol_q  <= wdata_i;
        hold_q <= pol_q ^ wdata_i;
      end
      if (wr_src) begin
        src_q  <= wdata_i;
        hold_q <= (src_q ^ wdata_i) & src_eff_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (addr_i == POL_ADDR)      rdata_q <= pol_q;
      else if (addr_i == SRC_ADDR) rdata_q <= src_q;
      else                         rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
  assign pol_o   = pol_q;
  assign src_o   = src_q;
  assign hold_o  = hold_q;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i != POL_ADDR && addr_i != SRC_ADDR) |=> (rdata_o == '0)); // R9
  AST_POL_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
    wr_pol |=> (pol_o == $past(wdata_i))); // R9
  AST_SRC_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
    wr_src |=> (src_o == $past(wdata_i))); // R7
endmodule

// File: rtl/irqfe_edge.sv
module irqfe_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic rise_i,
  input  logic hold_i,
  output logic irq_o
);
  logic prev_q, irq_q, hit;

  assign hit = rise_i ? (sel_i & ~prev_q) : (~sel_i & prev_q);

  always_ff @(posedge clk) begin
    // the previous-sample flop always follows the current source,
    // so after a retarget it holds the new source's level
    prev_q <= sel_i;
    if (rst || hold_i) irq_q <= 1'b0;
    else               irq_q <= hit;
  end

  assign irq_o = irq_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R2
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !irq_o); // R8
  AST_IRQ_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(sel_i) != $past(sel_i, 2))); // R3
endmodule

// File: rtl/edge_irq_frontend.sv
module edge_irq_frontend
  import irqfe_pkg::*;
#(
  parameter int unsigned           ADDR_W           = 12,
  parameter logic [ADDR_W-1:0]     POL_ADDR         = 12'hFCD,
  parameter logic [ADDR_W-1:0]     SRC_ADDR         = 12'hFCE,
  parameter int unsigned           SYNC_STAGES      = 2,
  parameter bit                    LINE0_FROM_PORTD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        porta_in,
  input  logic [7:0]        portd_in,
  input  logic              lvd_in,
  input  logic              cmp_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        irq_out
);
  localparam int unsigned SYNC_W = 2 * LINES + 2;

  logic [SYNC_W-1:0] raw_in, sync_in;
  line_vec_t pa_s, pd_s, pol, src, hold, sel, irq;
  logic lvd_s, cmp_s;

  assign raw_in = {cmp_in, lvd_in, portd_in, porta_in};

  irqfe_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  assign pa_s  = sync_in[LINES-1:0];
  assign pd_s  = sync_in[2*LINES-1:LINES];
  assign lvd_s = sync_in[2*LINES];
  assign cmp_s = sync_in[2*LINES+1];

  irqfe_regs #(.ADDR_W(ADDR_W), .POL_ADDR(POL_ADDR), .SRC_ADDR(SRC_ADDR)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata),
    .pol_o   (pol),
    .src_o   (src),
    .hold_o  (hold)
  );

  for (genvar x = 0; x < LINES; x++) begin : g_line
    if (x == 0) begin : g_fixed
      assign sel[x] = LINE0_FROM_PORTD ? pd_s[x] : pa_s[x];
    end else if (x == 6) begin : g_cmp
      assign sel[x] = src[x] ? cmp_s : pa_s[x];
    end else if (x == 7) begin : g_lvd
      assign sel[x] = src[x] ? lvd_s : pa_s[x];
    end else begin : g_portd
      assign sel[x] = src[x] ? pd_s[x] : pa_s[x];
    end

    irqfe_edge i_edge (
      .clk    (clk),
      .rst    (rst),
      .sel_i  (sel[x]),
      .rise_i (pol[x]),
      .hold_i (hold[x]),
      .irq_o  (irq[x])
    );
  end

  assign irq_out = irq;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && bus_rdata == '0)); // R1
  AST_LINE7_ALT: assert property (@(posedge clk) disable iff (rst)
    (src[7] && $stable(src[7]) && $stable(lvd_s) && $stable(pol[7])) |=> !irq_out[7]); // R4
endmodule

// File: tb/test_edge_irq_frontend.sv
`timescale 1ns/1ps
module test_edge_irq_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  porta_in = '0, portd_in = '0;
  logic        lvd_in = 1'b0, cmp_in = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, irq_out;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_frontend i_edge_irq_frontend (
    .clk(clk), .rst(rst), .porta_in(porta_in), .portd_in(portd_in),
    .lvd_in(lvd_in), .cmp_in(cmp_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  localparam logic [11:0] A_POL = 12'hFCD;
  localparam logic [11:0] A_SRC = 12'hFCE;

  // vector table: registers, inputs before, inputs after ({lvd,cmp}), expected pulse
  localparam int NV = 8;
  localparam logic [7:0] V_POL [NV] = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'h55};
  localparam logic [7:0] V_SRC [NV] = '{8'h00, 8'h00, 8'h00, 8'h3E, 8'h3E, 8'hC0, 8'hC0, 8'h01};
  localparam logic [7:0] V_PA0 [NV] = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hAA};
  localparam logic [7:0] V_PD0 [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [1:0] V_AL0 [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00};
  localparam logic [7:0] V_PA1 [NV] = '{8'h00, 8'hFF, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h55};
  localparam logic [7:0] V_PD1 [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
  localparam logic [1:0] V_AL1 [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00};
  localparam logic [7:0] V_EXP [NV] = '{8'hFF, 8'hFF, 8'h0F, 8'hC1, 8'h3E, 8'hC0, 8'hF0, 8'hFF};
  localparam string      V_TAG [NV] = '{"R2 R10", "R3 R10", "R3", "R6", "R6", "R4 R5", "R2 R4 R5", "R7 R10"};

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 irq in reset", irq_out, 8'h00);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst = 1'b0;
    chk("R1 irq after reset", irq_out, 8'h00);
    tick();
    chk("R1 irq first clock", irq_out, 8'h00);
    rd_reg(A_POL, rd); chk("R1 polarity reset value", rd, 8'h00);
    rd_reg(A_SRC, rd); chk("R1 source reset value", rd, 8'h00);

    // R9: read-back and unmapped
    wr_reg(A_POL, 8'hA5);
    rd_reg(A_POL, rd); chk("R9 polarity readback", rd, 8'hA5);
    wr_reg(A_SRC, 8'h5B);
    rd_reg(A_SRC, rd); chk("R7 R9 source readback incl bit0", rd, 8'h5B);
    rd_reg(12'h123, rd); chk("R9 unmapped read", rd, 8'h00);
    rd_reg(12'hFCF, rd); chk("R9 neighbour unmapped read", rd, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr_reg(A_POL, V_POL[v]);
      wr_reg(A_SRC, V_SRC[v]);
      porta_in = V_PA0[v]; portd_in = V_PD0[v];
      {lvd_in, cmp_in} = V_AL0[v];
      settle();
      porta_in = V_PA1[v]; portd_in = V_PD1[v];
      {lvd_in, cmp_in} = V_AL1[v];
      tick(); tick();
      chk({V_TAG[v], " no early pulse"}, irq_out, 8'h00);
      tick();
      chk({V_TAG[v], " pulse"}, irq_out, V_EXP[v]);
      tick();
      chk({V_TAG[v], " pulse is one cycle"}, irq_out, 8'h00);
    end

    // R8: retarget while another line sees a real edge in the same clock
    wr_reg(A_POL, 8'hFF);
    wr_reg(A_SRC, 8'h00);
    porta_in = 8'h00; portd_in = 8'hFF; {lvd_in, cmp_in} = 2'b00;
    settle();
    porta_in[7] = 1'b1;            // synchronized edge arrives two clocks later
    tick();
    bus_addr = A_SRC; bus_wdata = 8'h3E; bus_wr = 1'b1;
    tick();                        // write and line-7 edge share this clock
    bus_wr = 1'b0;
    tick();
    chk("R8 R10 only unchanged line fires", irq_out, 8'h80);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 no spurious after retarget", irq_out, 8'h00);
    end
    // the retargeted lines still detect fresh edges of their new source
    portd_in = 8'h00;
    settle();
    chk("R8 falling ignored with rising polarity", irq_out, 8'h00);
    portd_in = 8'hFF;
    tick(); tick(); tick();
    chk("R6 R8 new source detected", irq_out, 8'h3E);
    // polarity flip on held-high inputs gives no request
    wr_reg(A_POL, 8'h00);
    for (int k = 0; k < 3; k++) begin
      chk("R8 polarity change quiet", irq_out, 8'h00);
      tick();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule